// File: doc/BRIEF.md
# Scalar Crypto Bit-Manipulation Unit

This block is a pipelined 32-bit execution unit for the bit-manipulation operations used by scalar cryptography code. Each issue carries two 32-bit operands, a 5-bit immediate and a 4-bit internal operation code, which the unit uses in place of a RISC-V instruction word. The operations are the three rotates, the three inverted-operand logic operations, the two packing forms, the per-byte bit reversal, the byte reversal, and bit interleave and de-interleave.

Every operation takes the same number of cycles whatever the operand values are. A result comes out a fixed number of cycles after its issue, and a new operation may be issued on every cycle. The surrounding core decodes instructions, reads the register file and handles hazards. This unit only computes.

The reset input is asserted asynchronously. Its release is synchronized inside the block, so the unit stays in reset for two further clock edges after `rst_ni` rises.

Top module: `scbm_unit`

## Requirements
- R1: Opcode 0 rotates operand A right and opcode 1 rotates it left. Both use only bits 4:0 of operand B as the amount, so the upper bits of B have no effect on the result.
- R2: Opcode 2 rotates operand A right by the 5-bit immediate, and operand B is ignored.
- R3: Opcode 3 gives A AND NOT B, opcode 4 gives A OR NOT B, and opcode 5 gives NOT (A XOR B).
- R4: Opcode 6 places B[15:0] in result bits 31:16 and A[15:0] in result bits 15:0.
- R5: Opcode 7 places B[7:0] in result bits 15:8 and A[7:0] in result bits 7:0, and clears bits 31:16.
- R6: Opcode 8 reverses the bit order inside each byte of A. Opcode 9 reverses the order of the four bytes of A.
- R7: Opcode 10 (zip) sends A bit i to result bit 2i and A bit i+16 to result bit 2i+1, for i from 0 to 15. Opcode 11 (unzip) is its exact inverse, so unzip(zip(x)) equals x.
- R8: An issue with `in_valid_i` high on a rising edge gives exactly one result with `out_valid_o` high. That result is visible after the fifth rising edge, counting the capturing edge as the first. Issues on consecutive cycles give results on consecutive cycles, in the same order.
- R9: `out_result_o` is zero whenever `out_valid_o` is low. Opcodes 12 to 15 return a zero result.
- R10: While the reset is active and after it is released, `out_valid_o` stays low until an operation has been issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid_i | input | 1 | Issue strobe |
| in_op_i | input | 4 | Internal operation code |
| in_rs1_i | input | 32 | Operand A |
| in_rs2_i | input | 32 | Operand B |
| in_imm_i | input | 5 | Immediate rotate amount |
| out_valid_o | output | 1 | Result strobe |
| out_result_o | output | 32 | Result, zero when not valid |

## Verification
Every opcode is compared against a behavioural reference model using random operands. The rotates are also driven with amounts 0 and 31, and with the upper bits of operand B set, which shows whether the amount is masked and whether a left rotate is mixed up with a right rotate. Operands with a single hot bit and asymmetric byte patterns separate zip from unzip, and byte reversal from bit reversal within bytes. A round trip through zip and then unzip checks the inverse property. A burst of issues on consecutive cycles, followed by a gap, separates a correct fixed latency and ordering from a dropped, duplicated or shifted result.

// File: rtl/scbm_pkg.sv
package scbm_pkg;
  localparam int XLEN = 32;
  localparam int SHW  = $clog2(XLEN);

  typedef enum logic [3:0] {
    OP_ROR   = 4'd0,
    OP_ROL   = 4'd1,
    OP_RORI  = 4'd2,
    OP_ANDN  = 4'd3,
    OP_ORN   = 4'd4,
    OP_XNOR  = 4'd5,
    OP_PACK  = 4'd6,
    OP_PACKH = 4'd7,
    OP_BREV8 = 4'd8,
    OP_REV8  = 4'd9,
    OP_ZIP   = 4'd10,
    OP_UNZIP = 4'd11
  } scbm_op_e;
endpackage

// File: rtl/scbm_rotr.sv
// Logarithmic right rotator: one conditional stage per amount bit.
module scbm_rotr #(
  parameter int XLEN = 32,
  parameter int SHW  = 5
) (
  input  logic [XLEN-1:0] din_i,
  input  logic [SHW-1:0]  amt_i,
  output logic [XLEN-1:0] dout_o
);
  logic [XLEN-1:0] lvl [SHW+1];

  assign lvl[0] = din_i;

  for (genvar j = 0; j < SHW; j++) begin : g_lvl
    localparam int SH = 1 << j;
    assign lvl[j+1] = amt_i[j] ? {lvl[j][SH-1:0], lvl[j][XLEN-1:SH]} : lvl[j];
  end

  assign dout_o = lvl[SHW];
endmodule

// File: rtl/scbm_bitops.sv
// Logic, pack and bit-permutation operations (everything except rotates).
module scbm_bitops
  import scbm_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [3:0]      op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] res_o
);
  localparam int HALF   = XLEN / 2;
  localparam int NBYTES = XLEN / 8;

  logic [XLEN-1:0] brev_w, rev_w, zip_w, unzip_w;

  for (genvar k = 0; k < NBYTES; k++) begin : g_byte
    for (genvar m = 0; m < 8; m++) begin : g_bit
      assign brev_w[8*k + m] = a_i[8*k + 7 - m];
    end
    assign rev_w[8*k +: 8] = a_i[8*(NBYTES-1-k) +: 8];
  end

  for (genvar i = 0; i < HALF; i++) begin : g_zip
    assign zip_w[2*i]        = a_i[i];
    assign zip_w[2*i + 1]    = a_i[i + HALF];
    assign unzip_w[i]        = a_i[2*i];
    assign unzip_w[i + HALF] = a_i[2*i + 1];
  end

  always_comb begin
    res_o = '0;
    case (op_i)
      OP_ANDN:  res_o = a_i & ~b_i;
      OP_ORN:   res_o = a_i | ~b_i;
      OP_XNOR:  res_o = ~(a_i ^ b_i);
      OP_PACK:  res_o = {b_i[HALF-1:0], a_i[HALF-1:0]};
      OP_PACKH: res_o = {{(XLEN-16){1'b0}}, b_i[7:0], a_i[7:0]};
      OP_BREV8: res_o = brev_w;
      OP_REV8:  res_o = rev_w;
      OP_ZIP:   res_o = zip_w;
      OP_UNZIP: res_o = unzip_w;
      default:  res_o = '0;
    endcase
  end
endmodule

// File: rtl/scbm_delay.sv
// Valid-qualified delay line; data registers load only with their valid.
module scbm_delay #(
  parameter int W     = 32,
  parameter int DEPTH = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         vld_i,
  input  logic [W-1:0] dat_i,
  output logic         vld_o,
  output logic [W-1:0] dat_o
);
  if (DEPTH == 0) begin : g_pass
    assign vld_o = vld_i;
    assign dat_o = dat_i;
  end else begin : g_pipe
    logic         vld_q [DEPTH];
    logic [W-1:0] dat_q [DEPTH];
    logic         vld_in [DEPTH];
    logic [W-1:0] dat_in [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
      if (s == 0) begin : g_first
        assign vld_in[s] = vld_i;
        assign dat_in[s] = dat_i;
      end else begin : g_next
        assign vld_in[s] = vld_q[s-1];
        assign dat_in[s] = dat_q[s-1];
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) vld_q[s] <= 1'b0;
        else         vld_q[s] <= vld_in[s];
      end

      always_ff @(posedge clk_i) begin
        if (vld_in[s]) dat_q[s] <= dat_in[s];
      end
    end

    assign vld_o = vld_q[DEPTH-1];
    assign dat_o = dat_q[DEPTH-1];
  end
endmodule

// File: rtl/scbm_unit.sv
// Top: operand capture, one compute stage, then a delay line to the fixed latency.
module scbm_unit
  import scbm_pkg::*;
#(
  parameter int XLEN        = scbm_pkg::XLEN,
  parameter int PIPE_STAGES = 5,
  localparam int SHW        = $clog2(XLEN)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  input  logic [3:0]      in_op_i,
  input  logic [XLEN-1:0] in_rs1_i,
  input  logic [XLEN-1:0] in_rs2_i,
  input  logic [SHW-1:0]  in_imm_i,
  output logic            out_valid_o,
  output logic [XLEN-1:0] out_result_o
);
  localparam int TAIL = PIPE_STAGES - 2;

  // Reset synchronizer: asynchronous assert, synchronous release.
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  // Stage 1: operand capture.
  logic            s1_valid_q;
  logic [3:0]      s1_op_q;
  logic [XLEN-1:0] s1_a_q, s1_b_q;
  logic [SHW-1:0]  s1_imm_q;

  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int) s1_valid_q <= 1'b0;
    else            s1_valid_q <= in_valid_i;
  end

  always_ff @(posedge clk_i) begin
    if (in_valid_i) begin
      s1_op_q  <= in_op_i;
      s1_a_q   <= in_rs1_i;
      s1_b_q   <= in_rs2_i;
      s1_imm_q <= in_imm_i;
    end
  end

  // Compute (next state of stage 2).
  logic [SHW-1:0]  rot_amt;
  logic [XLEN-1:0] rot_res, bit_res, s2_res_d;
  logic            is_rot;

  always_comb begin
    is_rot  = 1'b1;
    rot_amt = s1_b_q[SHW-1:0];
    case (s1_op_q)
      OP_ROR:  rot_amt = s1_b_q[SHW-1:0];
      OP_ROL:  rot_amt = SHW'(0) - s1_b_q[SHW-1:0];
      OP_RORI: rot_amt = s1_imm_q;
      default: is_rot  = 1'b0;
    endcase
  end

  scbm_rotr #(.XLEN(XLEN), .SHW(SHW)) u_rotr (
    .din_i  (s1_a_q),
    .amt_i  (rot_amt),
    .dout_o (rot_res)
  );

  scbm_bitops #(.XLEN(XLEN)) u_bitops (
    .op_i  (s1_op_q),
    .a_i   (s1_a_q),
    .b_i   (s1_b_q),
    .res_o (bit_res)
  );

  assign s2_res_d = is_rot ? rot_res : bit_res;

  // Stage 2 register.
  logic            s2_valid_q;
  logic [XLEN-1:0] s2_res_q;

  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int) s2_valid_q <= 1'b0;
    else            s2_valid_q <= s1_valid_q;
  end

  always_ff @(posedge clk_i) begin
    if (s1_valid_q) s2_res_q <= s2_res_d;
  end

  // Remaining stages.
  logic            tail_vld;
  logic [XLEN-1:0] tail_dat;

  scbm_delay #(.W(XLEN), .DEPTH(TAIL)) u_delay (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .vld_i  (s2_valid_q),
    .dat_i  (s2_res_q),
    .vld_o  (tail_vld),
    .dat_o  (tail_dat)
  );

  assign out_valid_o  = tail_vld;
  assign out_result_o = tail_vld ? tail_dat : '0;
endmodule

// File: rtl/scbm_unit_chk.sv
module scbm_unit_chk
  import scbm_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int PIPE_STAGES = 5,
  localparam int SHW        = $clog2(XLEN)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            in_valid_i,
  input logic [3:0]      in_op_i,
  input logic [XLEN-1:0] in_rs1_i,
  input logic [XLEN-1:0] in_rs2_i,
  input logic [SHW-1:0]  in_imm_i,
  input logic            out_valid_o,
  input logic [XLEN-1:0] out_result_o
);
  // The checker's own history; reset released with the same two-edge lag.
  logic [1:0]      rsync_q;
  logic            vh_q [PIPE_STAGES];
  logic [3:0]      oh_q [PIPE_STAGES];
  logic [XLEN-1:0] ah_q [PIPE_STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rsync_q <= 2'b00;
    else         rsync_q <= {rsync_q[0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < PIPE_STAGES; s++) vh_q[s] <= 1'b0;
    end else begin
      vh_q[0] <= in_valid_i & rsync_q[1];
      for (int s = 1; s < PIPE_STAGES; s++) vh_q[s] <= vh_q[s-1];
    end
  end

  always_ff @(posedge clk_i) begin
    oh_q[0] <= in_op_i;
    ah_q[0] <= in_rs1_i;
    for (int s = 1; s < PIPE_STAGES; s++) begin
      oh_q[s] <= oh_q[s-1];
      ah_q[s] <= ah_q[s-1];
    end
  end

  logic [3:0]      op_d;
  logic [XLEN-1:0] a_d;
  assign op_d = oh_q[PIPE_STAGES-1];
  assign a_d  = ah_q[PIPE_STAGES-1];

  assert_latency_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o == vh_q[PIPE_STAGES-1]);

  assert_idle_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> out_result_o == '0);

  assert_undef_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && op_d >= 4'd12) |-> out_result_o == '0);

  assert_in_reset_R10: assert property (@(posedge clk_i)
    !rst_ni |-> !out_valid_o);

  assert_rot_ones_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && (op_d == OP_ROR || op_d == OP_ROL || op_d == OP_RORI))
      |-> $countones(out_result_o) == $countones(a_d));

  assert_packh_top_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && op_d == OP_PACKH) |-> out_result_o[XLEN-1:16] == '0);

  assert_byte_ones_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && (op_d == OP_BREV8 || op_d == OP_REV8))
      |-> $countones(out_result_o) == $countones(a_d));

  assert_zip_ones_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && (op_d == OP_ZIP || op_d == OP_UNZIP))
      |-> $countones(out_result_o) == $countones(a_d));
endmodule

bind scbm_unit scbm_unit_chk #(.XLEN(XLEN), .PIPE_STAGES(PIPE_STAGES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .in_valid_i   (in_valid_i),
  .in_op_i      (in_op_i),
  .in_rs1_i     (in_rs1_i),
  .in_rs2_i     (in_rs2_i),
  .in_imm_i     (in_imm_i),
  .out_valid_o  (out_valid_o),
  .out_result_o (out_result_o)
);

// File: tb/scbm_unit_tb_top.sv
module scbm_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 5;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        in_valid_i;
  logic [3:0]  in_op_i;
  logic [31:0] in_rs1_i, in_rs2_i;
  logic [4:0]  in_imm_i;
  logic        out_valid_o;
  logic [31:0] out_result_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  scbm_unit dut_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .in_valid_i   (in_valid_i),
    .in_op_i      (in_op_i),
    .in_rs1_i     (in_rs1_i),
    .in_rs2_i     (in_rs2_i),
    .in_imm_i     (in_imm_i),
    .out_valid_o  (out_valid_o),
    .out_result_o (out_result_o)
  );

  function automatic logic [31:0] rotr(input logic [31:0] x, input int n);
    logic [31:0] r = x;
    for (int i = 0; i < n; i++) r = {r[0], r[31:1]};
    return r;
  endfunction

  function automatic logic [31:0] ref_model(input logic [3:0] op, input logic [31:0] a,
                                            input logic [31:0] b, input logic [4:0] imm);
    logic [31:0] r = '0;
    case (op)
      4'd0: r = rotr(a, int'(b[4:0]));
      4'd1: r = rotr(a, (32 - int'(b[4:0])) % 32);
      4'd2: r = rotr(a, int'(imm));
      4'd3: r = a & ~b;
      4'd4: r = a | ~b;
      4'd5: r = ~(a ^ b);
      4'd6: r = {b[15:0], a[15:0]};
      4'd7: r = {16'h0, b[7:0], a[7:0]};
      4'd8: for (int i = 0; i < 32; i++) r[i] = a[(i/8)*8 + 7 - (i%8)];
      4'd9: r = {a[7:0], a[15:8], a[23:16], a[31:24]};
      4'd10: for (int i = 0; i < 16; i++) begin r[2*i] = a[i]; r[2*i+1] = a[i+16]; end
      4'd11: for (int i = 0; i < 16; i++) begin r[i] = a[2*i]; r[i+16] = a[2*i+1]; end
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  // Issue one operation (called at a negedge), return its result; checks latency.
  task automatic run_one(input string req, input logic [3:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic [4:0] imm, output logic [31:0] res);
    in_valid_i = 1'b1; in_op_i = op; in_rs1_i = a; in_rs2_i = b; in_imm_i = imm;
    @(negedge clk_i);
    in_valid_i = 1'b0; in_rs1_i = $urandom; in_rs2_i = $urandom; in_imm_i = 5'($urandom);
    repeat (LAT-2) @(negedge clk_i);
    check({req, " early-valid R8"}, {31'b0, out_valid_o}, 32'd0);
    @(negedge clk_i);
    check({req, " valid R8"}, {31'b0, out_valid_o}, 32'd1);
    res = out_result_o;
    check(req, res, ref_model(op, a, b, imm));
  endtask

  task automatic t_reset_R10();
    in_valid_i = 0; in_op_i = 0; in_rs1_i = 0; in_rs2_i = 0; in_imm_i = 0;
    rst_ni = 0;
    repeat (3) @(negedge clk_i);
    check("R10 in reset", {31'b0, out_valid_o}, 32'd0);
    rst_ni = 1;
    repeat (6) @(negedge clk_i);
    check("R10 after release", {31'b0, out_valid_o}, 32'd0);
    check("R9 idle result", out_result_o, 32'd0);
  endtask

  task automatic t_rotates_R1_R2();
    logic [31:0] r, a;
    int amts[4] = '{0, 31, 1, 13};
    foreach (amts[k]) begin
      a = $urandom;
      run_one("R1 ror", 4'd0, a, {27'h5A5A5A5, 5'(amts[k])}, 5'd0, r);
      run_one("R1 rol", 4'd1, a, {27'h7FFFFFF, 5'(amts[k])}, 5'd0, r);
      run_one("R2 rori", 4'd2, a, $urandom, 5'(amts[k]), r);
    end
    run_one("R1 rol by 1", 4'd1, 32'h8000_0001, 32'd1, 5'd0, r);
    check("R1 rol explicit", r, 32'h0000_0003);
  endtask

  task automatic t_logic_R3();
    logic [31:0] r;
    for (int k = 0; k < 4; k++) begin
      run_one("R3 andn", 4'd3, $urandom, $urandom, 5'd0, r);
      run_one("R3 orn",  4'd4, $urandom, $urandom, 5'd0, r);
      run_one("R3 xnor", 4'd5, $urandom, $urandom, 5'd0, r);
    end
  endtask

  task automatic t_pack_R4_R5();
    logic [31:0] r;
    run_one("R4 pack", 4'd6, 32'hDEAD_BEEF, 32'h1234_5678, 5'd0, r);
    check("R4 pack explicit", r, 32'h5678_BEEF);
    run_one("R5 packh", 4'd7, 32'hFFFF_FFA5, 32'hFFFF_FF3C, 5'd0, r);
    check("R5 packh explicit", r, 32'h0000_3CA5);
    run_one("R4 pack rand", 4'd6, $urandom, $urandom, 5'd0, r);
    run_one("R5 packh rand", 4'd7, $urandom, $urandom, 5'd0, r);
  endtask

  task automatic t_bytes_R6();
    logic [31:0] r;
    run_one("R6 brev8", 4'd8, 32'h0180_F001, 32'd0, 5'd0, r);
    check("R6 brev8 explicit", r, 32'h8001_0F80);
    run_one("R6 rev8", 4'd9, 32'h1122_3344, 32'd0, 5'd0, r);
    check("R6 rev8 explicit", r, 32'h4433_2211);
    run_one("R6 brev8 rand", 4'd8, $urandom, $urandom, 5'd0, r);
    run_one("R6 rev8 rand", 4'd9, $urandom, $urandom, 5'd0, r);
  endtask

  task automatic t_zip_R7();
    logic [31:0] r, z, x;
    run_one("R7 zip hi bit", 4'd10, 32'h0001_0000, 32'd0, 5'd0, r);
    check("R7 zip bit16->bit1", r, 32'h0000_0002);
    run_one("R7 unzip bit1", 4'd11, 32'h0000_0002, 32'd0, 5'd0, r);
    check("R7 unzip bit1->bit16", r, 32'h0001_0000);
    for (int k = 0; k < 3; k++) begin
      x = $urandom;
      run_one("R7 zip rand", 4'd10, x, $urandom, 5'd0, z);
      run_one("R7 unzip rand", 4'd11, z, $urandom, 5'd0, r);
      check("R7 round trip", r, x);
    end
  endtask

  task automatic t_burst_R8();
    logic [3:0]  ops [10];
    logic [31:0] as [10], bs [10];
    logic [4:0]  ims [10];
    for (int i = 0; i < 10; i++) begin
      ops[i] = 4'(i % 12); as[i] = $urandom; bs[i] = $urandom; ims[i] = 5'($urandom);
    end
    fork
      begin
        for (int i = 0; i < 10; i++) begin
          in_valid_i = 1; in_op_i = ops[i]; in_rs1_i = as[i]; in_rs2_i = bs[i]; in_imm_i = ims[i];
          @(negedge clk_i);
        end
        in_valid_i = 0;
      end
      begin
        repeat (LAT) @(posedge clk_i);
        for (int i = 0; i < 10; i++) begin
          @(negedge clk_i);
          check("R8 burst valid", {31'b0, out_valid_o}, 32'd1);
          check("R8 burst order", out_result_o, ref_model(ops[i], as[i], bs[i], ims[i]));
        end
        @(negedge clk_i);
        check("R8 no extra result", {31'b0, out_valid_o}, 32'd0);
      end
    join
  endtask

  task automatic t_undef_R9();
    logic [31:0] r;
    for (int op = 12; op < 16; op++) begin
      run_one("R9 undefined op", 4'(op), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd3, r);
      check("R9 undefined zero", r, 32'd0);
    end
    @(negedge clk_i);
    check("R9 idle zero", out_result_o, 32'd0);
  endtask

  initial begin
    @(negedge clk_i);
    t_reset_R10();
    t_rotates_R1_R2();
    t_logic_R3();
    t_pack_R4_R5();
    t_bytes_R6();
    t_zip_R7();
    t_burst_R8();
    t_undef_R9();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule